// File: doc/BRIEF.md
# External Slave Sync Reset Aligner

This block is the timing front end of a video encoder that runs as a slave to
outside sync. It receives a horizontal reset pulse and a vertical reset pulse
from elsewhere. It finds the active edge of each pulse under a programmable
polarity. From those edges it keeps an internal pixel counter and an internal
line counter aligned to the outside timing.

A horizontal edge reloads the pixel counter. A mode input chooses what that
edge stands for:

- the start of horizontal blanking, which loads zero and begins a new line; or
- the start of active video, which loads a fixed clock offset and leaves the line number alone.

A vertical edge forces the line counter to line 4, where an odd field begins. In
normal operation this happens only when the vertical edge lands within a small
window of a horizontal edge, before it or after it. In frame-sync mode every
vertical edge is taken at once.

The block tracks which of the two analog frame phases is running: fields 1-2 or
fields 3-4. An external field input can set that phase, and is sampled each time
a frame begins. A strobe marks every frame that begins fields 1-2, so that a
subcarrier generator can restart its phase there. There is no data path, so
there is no valid/ready interface. Every pin is a plain control or status level,
or a one-cycle strobe.

Top module: `sync_reset_aligner`

## Requirements
- R1: An active edge is a change of a reset input into its active level: high when its polarity input is 1, low when it is 0. Inputs are registered once and then compared with a second registered copy. A change back to the idle level has no effect.
- R2: A horizontal active edge raises `h_load` for one cycle, visible in the cycle after the input is sampled. On the next clock, with `hmark_active`=0, the pixel counter loads 0 and the line advances. With `hmark_active`=1 it loads ACTIVE_OFS and the line is unchanged.
- R3: Without edges, the pixel counter steps by one per clock from 0 to LINE_CLKS-1 and then wraps to 0, advancing the line. Lines count 1 to LINES and wrap to 1. The reset state is pixel 0, line 1.
- R4: With `frame_sync`=0, a vertical active edge at most WIN cycles before or after a horizontal active edge raises `v_load` in the cycle where the later of the two edges is seen. The line counter then becomes 4 on the next clock.
- R5: With `frame_sync`=0, a vertical active edge with no horizontal active edge within WIN cycles raises no `v_load` and leaves the line count unchanged.
- R6: With `frame_sync`=1, every vertical active edge raises `v_load` and sets line 4, whatever the horizontal input does. The pixel counter keeps running.
- R7: `field_odd` is 1 exactly while the line counter is in 4 .. (LINES+1)/2+2, and 0 on all other lines.
- R8: A frame begins when the line enters 4, whether by a vertical load or by advancing from line 3. At that point `field_12` (1 = analog fields 1-2) toggles if `field_en`=0. If `field_en`=1 it takes the value of `field_in`.
- R9: `sc_rst` pulses for one cycle, in the same cycle as the frame-start decision, exactly when the new `field_12` value will be 1.
- R10: During reset, all strobes are 0 and `field_12` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hrst_in | input | 1 | External horizontal reset pulse |
| vrst_in | input | 1 | External vertical reset pulse |
| field_in | input | 1 | External analog-frame phase, 1 = fields 1-2 |
| hpol | input | 1 | Horizontal active level (1 = high) |
| vpol | input | 1 | Vertical active level (1 = high) |
| hmark_active | input | 1 | 1: horizontal edge marks active video start; 0: blanking start |
| frame_sync | input | 1 | 1: vertical edges reset the line unconditionally |
| field_en | input | 1 | 1: `field_in` dictates the frame phase |
| h_load | output | 1 | Pixel counter load strobe |
| v_load | output | 1 | Line counter load strobe |
| sc_rst | output | 1 | Subcarrier phase reset strobe |
| pix_cnt | output | PW | Current pixel counter |
| line_cnt | output | LW | Current line number, 1-based |
| field_odd | output | 1 | 1 during the odd field |
| field_12 | output | 1 | 1 during analog fields 1-2 |

## Verification
The bound checker watches several rules on every clock:

- the pixel counter steps by one when no load or wrap is due;
- the value loaded after each horizontal strobe follows the mode;
- the line goes to 4 after every vertical strobe;
- both counters stay in range;
- `sc_rst` is always followed by fields 1-2;
- a forced phase equals the sampled field input.

The coincidence window's edges can only be shown by the bench's scenarios. These
cover a vertical edge exactly WIN cycles after, and exactly WIN cycles before, a
horizontal edge, and one just outside. The scenarios also show that the trailing
edge of an inverted pulse is ignored, and that a frame with the field input held
high is not toggled away.

// File: rtl/sra_pkg.sv
package sra_pkg;
  // Line on which the odd field starts after a vertical load.
  localparam int ODD_START_LINE = 4;

  // First line of the even field for a frame of the given length.
  function automatic int even_start_line(input int lines);
    return (lines + 1) / 2 + 3;
  endfunction

  // Index of the two reset channels.
  typedef enum int {CH_H = 0, CH_V = 1} sync_ch_e;
endpackage

// File: rtl/sra_edge.sv
// Polarity-corrected active-edge detector for one reset input.
module sra_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic pol,
  output logic act_edge
);
  logic lvl_q, lvl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      lvl_d <= 1'b0;
    end else begin
      lvl_q <= pol ? raw : ~raw;
      lvl_d <= lvl_q;
    end
  end

  assign act_edge = lvl_q & ~lvl_d;
endmodule

// File: rtl/sra_coinc.sv
// Decides whether a vertical edge is accepted, using a symmetric window
// of WIN cycles around the horizontal edge, or unconditionally in frame-sync.
module sra_coinc #(
  parameter int WIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic h_edge,
  input  logic v_edge,
  input  logic frame_sync,
  output logic v_accept
);
  localparam int AW = $clog2(WIN + 2);
  localparam logic [AW-1:0] WIN_C = AW'(WIN);

  logic          h_seen;
  logic [AW-1:0] h_age;
  logic          v_pend;
  logic [AW-1:0] v_age;
  logic          v_now, v_late;

  assign v_now    = v_edge && (frame_sync || h_edge || (h_seen && h_age <= WIN_C));
  assign v_late   = h_edge && !frame_sync && v_pend && v_age <= WIN_C;
  assign v_accept = v_now || v_late;

  // age of the latest horizontal edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_seen <= 1'b0;
      h_age  <= '0;
    end else if (h_edge) begin
      h_seen <= 1'b1;
      h_age  <= AW'(1);
    end else if (h_seen) begin
      if (h_age <= WIN_C) h_age <= h_age + AW'(1);
      else                h_seen <= 1'b0;
    end
  end

  // vertical edge waiting for a following horizontal edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_pend <= 1'b0;
      v_age  <= '0;
    end else if (v_edge && !v_now) begin
      v_pend <= 1'b1;
      v_age  <= AW'(1);
    end else if (v_pend) begin
      if (v_accept || v_age >= WIN_C) v_pend <= 1'b0;
      else                            v_age  <= v_age + AW'(1);
    end
  end
endmodule

// File: rtl/sra_timing.sv
// Pixel and line counters with field and analog-frame phase tracking.
module sra_timing
  import sra_pkg::*;
#(
  parameter int LINE_CLKS  = 858,
  parameter int LINES      = 525,
  parameter int ACTIVE_OFS = 138,
  localparam int PW = $clog2(LINE_CLKS),
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_edge,
  input  logic          v_accept,
  input  logic          hmark_active,
  input  logic          field_en,
  input  logic          field_in,
  output logic [PW-1:0] pix_cnt,
  output logic [LW-1:0] line_cnt,
  output logic          field_12,
  output logic          sc_rst,
  output logic          field_odd
);
  localparam int F2 = even_start_line(LINES);

  logic          pix_last, adv, frame_start, pair_next;
  logic [PW-1:0] pix_next;
  logic [LW-1:0] line_next;

  assign pix_last = (pix_cnt == PW'(LINE_CLKS - 1));
  assign adv      = h_edge ? !hmark_active : pix_last;

  always_comb begin
    if (h_edge)        pix_next = hmark_active ? PW'(ACTIVE_OFS) : '0;
    else if (pix_last) pix_next = '0;
    else               pix_next = pix_cnt + PW'(1);
  end

  always_comb begin
    if (v_accept)                       line_next = LW'(ODD_START_LINE);
    else if (adv && line_cnt == LW'(LINES)) line_next = LW'(1);
    else if (adv)                       line_next = line_cnt + LW'(1);
    else                                line_next = line_cnt;
  end

  assign frame_start = v_accept || (adv && line_cnt == LW'(ODD_START_LINE - 1));
  assign pair_next   = field_en ? field_in : ~field_12;
  assign sc_rst      = frame_start && pair_next;
  assign field_odd   = (line_cnt >= LW'(ODD_START_LINE)) && (line_cnt < LW'(F2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_cnt  <= '0;
      line_cnt <= LW'(1);
      field_12 <= 1'b0;
    end else begin
      pix_cnt  <= pix_next;
      line_cnt <= line_next;
      if (frame_start) field_12 <= pair_next;
    end
  end
endmodule

// File: rtl/sync_reset_aligner.sv
module sync_reset_aligner
  import sra_pkg::*;
#(
  parameter int LINE_CLKS  = 858,
  parameter int LINES      = 525,
  parameter int ACTIVE_OFS = 138,
  parameter int WIN        = 2,
  localparam int PW = $clog2(LINE_CLKS),
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hrst_in,
  input  logic          vrst_in,
  input  logic          field_in,
  input  logic          hpol,
  input  logic          vpol,
  input  logic          hmark_active,
  input  logic          frame_sync,
  input  logic          field_en,
  output logic          h_load,
  output logic          v_load,
  output logic          sc_rst,
  output logic [PW-1:0] pix_cnt,
  output logic [LW-1:0] line_cnt,
  output logic          field_odd,
  output logic          field_12
);
  logic [1:0] raw, pol, edges;

  assign raw[CH_H] = hrst_in;
  assign raw[CH_V] = vrst_in;
  assign pol[CH_H] = hpol;
  assign pol[CH_V] = vpol;

  for (genvar i = 0; i < 2; i++) begin : g_edge
    sra_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (raw[i]),
      .pol      (pol[i]),
      .act_edge (edges[i])
    );
  end

  assign h_load = edges[CH_H];

  sra_coinc #(.WIN(WIN)) u_coinc (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_edge     (edges[CH_H]),
    .v_edge     (edges[CH_V]),
    .frame_sync (frame_sync),
    .v_accept   (v_load)
  );

  sra_timing #(
    .LINE_CLKS  (LINE_CLKS),
    .LINES      (LINES),
    .ACTIVE_OFS (ACTIVE_OFS)
  ) u_timing (
    .clk          (clk),
    .rst_n        (rst_n),
    .h_edge       (edges[CH_H]),
    .v_accept     (v_load),
    .hmark_active (hmark_active),
    .field_en     (field_en),
    .field_in     (field_in),
    .pix_cnt      (pix_cnt),
    .line_cnt     (line_cnt),
    .field_12     (field_12),
    .sc_rst       (sc_rst),
    .field_odd    (field_odd)
  );
endmodule

// File: rtl/sync_reset_aligner_chk.sv
module sync_reset_aligner_chk #(
  parameter int LINE_CLKS  = 858,
  parameter int LINES      = 525,
  parameter int ACTIVE_OFS = 138,
  localparam int PW = $clog2(LINE_CLKS),
  localparam int LW = $clog2(LINES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          field_in,
  input logic          hmark_active,
  input logic          field_en,
  input logic          h_load,
  input logic          v_load,
  input logic          sc_rst,
  input logic [PW-1:0] pix_cnt,
  input logic [LW-1:0] line_cnt,
  input logic          field_12
);
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_load && pix_cnt != PW'(LINE_CLKS - 1)) |=> pix_cnt == $past(pix_cnt) + PW'(1)); // R3
  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt != '0 && line_cnt <= LW'(LINES)); // R3
  AST_HLOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (h_load && !hmark_active) |=> pix_cnt == '0); // R2
  AST_HLOAD_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    (h_load && hmark_active) |=> pix_cnt == PW'(ACTIVE_OFS)); // R2
  AST_VLOAD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    v_load |=> line_cnt == LW'(4)); // R4
  AST_SC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    sc_rst |=> field_12); // R9
  AST_FORCED_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (field_en && v_load) |=> field_12 == $past(field_in)); // R8
endmodule

bind sync_reset_aligner sync_reset_aligner_chk #(
  .LINE_CLKS  (LINE_CLKS),
  .LINES      (LINES),
  .ACTIVE_OFS (ACTIVE_OFS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .field_in     (field_in),
  .hmark_active (hmark_active),
  .field_en     (field_en),
  .h_load       (h_load),
  .v_load       (v_load),
  .sc_rst       (sc_rst),
  .pix_cnt      (pix_cnt),
  .line_cnt     (line_cnt),
  .field_12     (field_12)
);

// File: tb/sync_reset_aligner_test.sv
module sync_reset_aligner_test;
  localparam int LC = 40, LN = 13, OFS = 10, WN = 2;
  localparam int PW = $clog2(LC), LW = $clog2(LN + 1);

  // observed output selectors
  localparam int S_PIX = 0, S_LINE = 1, S_HL = 2, S_VL = 3, S_SC = 4, S_ODD = 5, S_PAIR = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hrst_in = 1'b0, vrst_in = 1'b0, field_in = 1'b0;
  logic hpol = 1'b1, vpol = 1'b1, hmark_active = 1'b0, frame_sync = 1'b0, field_en = 1'b0;
  logic h_load, v_load, sc_rst, field_odd, field_12;
  logic [PW-1:0] pix_cnt;
  logic [LW-1:0] line_cnt;

  int cyc = 0, checks = 0, fails = 0, base = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    int    sel;
    int    exp;
    string req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sync_reset_aligner #(.LINE_CLKS(LC), .LINES(LN), .ACTIVE_OFS(OFS), .WIN(WN)) uut (
    .clk(clk), .rst_n(rst_n), .hrst_in(hrst_in), .vrst_in(vrst_in), .field_in(field_in),
    .hpol(hpol), .vpol(vpol), .hmark_active(hmark_active), .frame_sync(frame_sync),
    .field_en(field_en), .h_load(h_load), .v_load(v_load), .sc_rst(sc_rst),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .field_odd(field_odd), .field_12(field_12)
  );

  function automatic int observe(input int sel);
    case (sel)
      S_PIX:   return int'(pix_cnt);
      S_LINE:  return int'(line_cnt);
      S_HL:    return int'(h_load);
      S_VL:    return int'(v_load);
      S_SC:    return int'(sc_rst);
      S_ODD:   return int'(field_odd);
      default: return int'(field_12);
    endcase
  endfunction

  // driver side: push expectation relative to base
  task automatic expect_at(input int rel, input int sel, input int val, input string req);
    exp_t e;
    e.due = base + rel; e.sel = sel; e.exp = val; e.req = req;
    sb.push_back(e);
  endtask

  task automatic to_rel(input int rel);
    while (cyc < base + rel) @(negedge clk);
  endtask

  // monitor: pop and compare items as their cycle arrives
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      int act;
      e = sb.pop_front();
      act = observe(e.sel);
      checks++;
      if (e.due != cyc || act != e.exp) begin
        fails++;
        $display("FAIL %s sel=%0d cyc=%0d actual=%0d expected=%0d", e.req, e.sel, cyc, act, e.exp);
      end
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    base = 0;
    expect_at(cyc + 1, S_PIX, 0, "R10");
    expect_at(cyc + 1, S_LINE, 1, "R10");
    expect_at(cyc + 1, S_PAIR, 0, "R10");
    expect_at(cyc + 1, S_HL, 0, "R10");
    expect_at(cyc + 1, S_SC, 0, "R10");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    base = cyc;

    // R3 free running count and wrap
    expect_at(5, S_PIX, 5, "R3");
    expect_at(39, S_LINE, 1, "R3");
    expect_at(40, S_PIX, 0, "R3");
    expect_at(40, S_LINE, 2, "R3");

    // R2 blanking-mode horizontal load
    to_rel(50); hrst_in = 1'b1;
    expect_at(51, S_HL, 1, "R2");
    expect_at(52, S_PIX, 0, "R2");
    expect_at(52, S_LINE, 3, "R2");
    to_rel(51); hrst_in = 1'b0;

    // R1 inverted polarity, trailing change ignored; line 3->4 starts a frame
    to_rel(60); hpol = 1'b0; hrst_in = 1'b1;
    to_rel(70); hrst_in = 1'b0;
    expect_at(71, S_HL, 1, "R1");
    expect_at(71, S_SC, 1, "R9");
    expect_at(72, S_PIX, 0, "R1");
    expect_at(72, S_LINE, 4, "R1");
    expect_at(72, S_PAIR, 1, "R8");
    expect_at(72, S_HL, 0, "R1");
    expect_at(75, S_PIX, 3, "R1");
    to_rel(71); hrst_in = 1'b1;
    to_rel(80); hpol = 1'b1; hrst_in = 1'b0;

    // R2 active-video mode load of the offset, line unchanged
    to_rel(90); hmark_active = 1'b1;
    to_rel(100); hrst_in = 1'b1;
    expect_at(101, S_HL, 1, "R2");
    expect_at(102, S_PIX, OFS, "R2");
    expect_at(102, S_LINE, 4, "R2");
    to_rel(101); hrst_in = 1'b0;
    to_rel(105); hmark_active = 1'b0;

    // R4 vertical edge WIN cycles after horizontal edge
    to_rel(140); hrst_in = 1'b1;
    to_rel(141); hrst_in = 1'b0;
    to_rel(142); vrst_in = 1'b1;
    expect_at(142, S_LINE, 6, "R4");
    expect_at(143, S_VL, 1, "R4");
    expect_at(143, S_SC, 0, "R9");
    expect_at(144, S_LINE, 4, "R4");
    expect_at(144, S_PAIR, 0, "R8");
    expect_at(144, S_ODD, 1, "R7");
    to_rel(143); vrst_in = 1'b0;

    // R4 vertical edge WIN cycles before horizontal edge
    to_rel(200); vrst_in = 1'b1;
    expect_at(201, S_VL, 0, "R4");
    to_rel(201); vrst_in = 1'b0;
    to_rel(202); hrst_in = 1'b1;
    expect_at(203, S_VL, 1, "R4");
    expect_at(203, S_SC, 1, "R9");
    expect_at(204, S_LINE, 4, "R4");
    expect_at(204, S_PIX, 0, "R4");
    expect_at(204, S_PAIR, 1, "R8");
    to_rel(203); hrst_in = 1'b0;

    // R5 vertical edge outside the window
    to_rel(230); vrst_in = 1'b1;
    expect_at(231, S_VL, 0, "R5");
    to_rel(231); vrst_in = 1'b0;
    to_rel(234); hrst_in = 1'b1;
    expect_at(235, S_VL, 0, "R5");
    expect_at(236, S_LINE, 5, "R5");
    to_rel(235); hrst_in = 1'b0;

    // R6 frame-sync: lone vertical edge
    to_rel(250); frame_sync = 1'b1;
    to_rel(260); vrst_in = 1'b1;
    expect_at(261, S_VL, 1, "R6");
    expect_at(262, S_LINE, 4, "R6");
    expect_at(262, S_PIX, 26, "R6");
    to_rel(261); vrst_in = 1'b0;
    to_rel(265); frame_sync = 1'b0;

    // R8 field input dictates phase
    to_rel(270); field_en = 1'b1; field_in = 1'b1;
    to_rel(300); hrst_in = 1'b1; vrst_in = 1'b1;
    expect_at(301, S_SC, 1, "R9");
    expect_at(302, S_PAIR, 1, "R8");
    expect_at(302, S_LINE, 4, "R4");
    to_rel(301); hrst_in = 1'b0; vrst_in = 1'b0;
    to_rel(320); hrst_in = 1'b1; vrst_in = 1'b1;
    expect_at(321, S_SC, 1, "R9");
    expect_at(322, S_PAIR, 1, "R8");
    to_rel(321); hrst_in = 1'b0; vrst_in = 1'b0;
    to_rel(330); field_in = 1'b0;
    to_rel(340); hrst_in = 1'b1; vrst_in = 1'b1;
    expect_at(341, S_SC, 0, "R9");
    expect_at(342, S_PAIR, 0, "R8");
    to_rel(341); hrst_in = 1'b0; vrst_in = 1'b0;

    // R7 field boundary and R3 line wrap
    expect_at(581, S_LINE, 9, "R7");
    expect_at(581, S_ODD, 1, "R7");
    expect_at(583, S_LINE, 10, "R7");
    expect_at(583, S_ODD, 0, "R7");
    expect_at(742, S_LINE, 1, "R3");
    expect_at(742, S_ODD, 0, "R7");
    to_rel(760);
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 5000) @(negedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog cyc=%0d actual=hung expected=done", cyc);
    end
    if (sb.size() > 0) begin
      checks += sb.size(); fails += sb.size();
      $display("FAIL %s leftover actual=%0d expected=0", sb[0].req, sb.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule